// File: doc/BRIEF.md
# Zero-Turnaround Synchronous SRAM Model

This block is a cycle-accurate, synthesizable model of a pipelined synchronous static RAM. Command, address, chip enables and byte lane enables are all registered on the rising clock edge. Read data leaves the block two cycles after its command. Write data is also taken two cycles after its command, so a write's data slot lines up exactly with a read's data slot. The controller can therefore mix reads and writes back to back in any order, and the shared data bus never needs an idle turnaround cycle.

A new access starts when the load control is low and all three chip enables are active. With the control high, the block continues the current burst (or the current deselect) and ignores the address, chip enable and direction inputs. A separate sequencer generates the burst addresses. The two low address bits step in either an XOR (interleaved) order or a modulo-four add (linear) order, chosen by a static input.

A clock-enable input freezes every piece of state for a cycle. An asynchronous output enable can turn the drivers off at any time. Write data arrives on a dedicated input. Read data and its drive qualifier are brought out on their own ports, next to the shared tri-state bus. The storage array is small, and its size is set by parameters.

Top module: `zt_sram`

## Requirements
- R1: A read registered at edge E (loaded, selected, `rd_nwr`=1) drives the word at its address on `rdata`/`dq` between edges E+1 and E+2, with `rdata_oe`=1 while `out_en_n`=0.
- R2: Write data for a command registered at edge E is taken from `wdata` at edge E+2 (not counting stalled edges). A read of the same address issued on the very next cycle returns the newly written bytes.
- R3: A new access starts only when `advance`=0, `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0. Any other chip enable combination with `advance`=0 is a deselect: its data slot is undriven and nothing is written.
- R4: With `advance`=1 after a read or write, `addr`, `rd_nwr` and the chip enables are ignored, and the same operation type continues at the next burst address.
- R5: Burst addresses keep the upper address bits and step the two low bits. With `linear_order`=0 the low bits are start XOR count; with `linear_order`=1 they are (start + count) mod 4. The count is 1, 2 and 3 for the continuations and wraps back to the start address after the fourth access.
- R6: `lane_wr_n[i]`=0 writes bits [8i+7:8i] of the word and leaves other lanes unchanged. A write with every bit of `lane_wr_n` high is a write abort that changes nothing. `lane_wr_n` is sampled on every write cycle, including continuations.
- R7: With `cke_n`=1 at an edge, no state changes and no write is performed. A read slot keeps driving the same data, and an undriven slot stays undriven.
- R8: The bus is never driven in a write data slot. `out_en_n`=1 turns off `rdata_oe` and `dq` immediately, without waiting for a clock edge.
- R9: `advance`=1 after a deselect continues the deselect: its slot is undriven and no write happens.
- R10: An edge with `rst_n`=0 empties the pipeline and ends any burst. Afterwards the bus is undriven, and `advance`=1 acts as a continued deselect. Array contents are not cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cke_n | input | 1 | Clock enable, active low; high freezes the block for that cycle |
| sel_a_n | input | 1 | Chip enable, active low |
| sel_b | input | 1 | Chip enable, active high |
| sel_c_n | input | 1 | Chip enable, active low |
| advance | input | 1 | 0 loads a new command, 1 continues the burst or deselect |
| rd_nwr | input | 1 | 1 read, 0 write; sampled only on a load |
| lane_wr_n | input | LANES | Byte lane write enables, active low |
| addr | input | ADDR_W | Word address, sampled on a load |
| linear_order | input | 1 | Burst order: 0 XOR order, 1 modulo-four add order |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| wdata | input | LANES*8 | Write data, sampled in the write data slot |
| rdata | output | LANES*8 | Registered read data |
| rdata_oe | output | 1 | High while the block drives the bus |
| dq | inout | LANES*8 | Shared data bus, driven with `rdata` when `rdata_oe` is high |

## Verification
The case that is hardest to reach is a read issued in the cycle right after a write to the same word. The read takes its data from the array at the same edge that commits the write, so it only returns the new bytes through the forwarding path. This case is harder still when the write updates only some byte lanes. The stimulus table reaches it with a full write, then a two-lane write to the same address, then an immediate read of that address. The same table also sets up stalls in the middle of read and write bursts, a continued deselect that carries write-like fields, and a write abort followed by a read-back. A directed section toggles the output enable inside a live read slot and resets the block in the middle of a burst.

// File: rtl/zt_sram_pkg.sv
`timescale 1ns/100ps
// Shared constants and types of the zero-turnaround SRAM model.
// Assumes byte-wide lanes throughout the block.
package zt_sram_pkg;
    localparam int LANE_W = 8;

    // Low-address stepping order used by the burst sequencer.
    typedef enum logic {
        ORDER_XOR = 1'b0,
        ORDER_ADD = 1'b1
    } burst_order_e;
endpackage

// File: rtl/zt_burst_seq.sv
`timescale 1ns/100ps
// Burst address sequencer.
// Keeps the start address and a CW-bit access count. step_addr is the address
// of the next continuation access. The upper bits come from the start address,
// and the low CW bits follow the selected order, wrapping every 2**CW accesses.
// Assumes load and step are already gated by the clock enable.
module zt_burst_seq
    import zt_sram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int CW     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              order,
    output logic [ADDR_W-1:0] step_addr
);
    logic [ADDR_W-1:0] base_q;
    logic [CW-1:0]     cnt_q;
    logic [CW-1:0]     cnt_nx;
    logic [CW-1:0]     low;

    // Count of the access that the next continuation issues.
    assign cnt_nx = cnt_q + CW'(1);

    // Low address bits for that access in the chosen order.
    always_comb begin
        if (burst_order_e'(order) == ORDER_ADD) low = base_q[CW-1:0] + cnt_nx;
        else                                    low = base_q[CW-1:0] ^ cnt_nx;
    end

    assign step_addr = {base_q[ADDR_W-1:CW], low};

    // Capture the start on a load and advance the count on each continuation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            cnt_q  <= '0;
        end else if (load) begin
            base_q <= addr_in;
            cnt_q  <= '0;
        end else if (step) begin
            cnt_q  <= cnt_nx;
        end
    end
endmodule

// File: rtl/zt_cmd_pipe.sv
`timescale 1ns/100ps
// Command pipeline: DEPTH register stages that carry valid, direction,
// address and lane enables. mid_* is the next-to-last stage, where reads
// fetch their data. out_* is the last stage, which owns the data slot.
// Assumes DEPTH >= 2. hold freezes every stage.
module zt_cmd_pipe #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int DEPTH  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold,
    input  logic              in_valid,
    input  logic              in_wr,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [LANES-1:0]  in_lane_n,
    output logic              mid_valid,
    output logic              mid_wr,
    output logic [ADDR_W-1:0] mid_addr,
    output logic              out_valid,
    output logic              out_wr,
    output logic [ADDR_W-1:0] out_addr,
    output logic [LANES-1:0]  out_lane_n
);
    logic              v_q [1:DEPTH];
    logic              w_q [1:DEPTH];
    logic [ADDR_W-1:0] a_q [1:DEPTH];
    logic [LANES-1:0]  l_q [1:DEPTH];

    for (genvar g = 1; g <= DEPTH; g++) begin : g_stage
        logic              pv;
        logic              pw;
        logic [ADDR_W-1:0] pa;
        logic [LANES-1:0]  pl;
        if (g == 1) begin : g_head
            assign pv = in_valid;
            assign pw = in_wr;
            assign pa = in_addr;
            assign pl = in_lane_n;
        end else begin : g_body
            assign pv = v_q[g-1];
            assign pw = w_q[g-1];
            assign pa = a_q[g-1];
            assign pl = l_q[g-1];
        end

        // Shift one stage forward unless the clock enable holds the pipe.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                v_q[g] <= 1'b0;
                w_q[g] <= 1'b0;
                a_q[g] <= '0;
                l_q[g] <= '1;
            end else if (!hold) begin
                v_q[g] <= pv;
                w_q[g] <= pw;
                a_q[g] <= pa;
                l_q[g] <= pl;
            end
        end
    end

    assign mid_valid  = v_q[DEPTH-1];
    assign mid_wr     = w_q[DEPTH-1];
    assign mid_addr   = a_q[DEPTH-1];
    assign out_valid  = v_q[DEPTH];
    assign out_wr     = w_q[DEPTH];
    assign out_addr   = a_q[DEPTH];
    assign out_lane_n = l_q[DEPTH];
endmodule

// File: rtl/zt_byte_array.sv
`timescale 1ns/100ps
// Storage array split into independent byte lanes.
// Each lane has a synchronous write gated by its active-low lane enable, and
// an asynchronous read. Contents are not reset.
module zt_byte_array
    import zt_sram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4
) (
    input  logic                    clk,
    input  logic                    we,
    input  logic [ADDR_W-1:0]       waddr,
    input  logic [LANES-1:0]        wlane_n,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic [ADDR_W-1:0]       raddr,
    output logic [LANES*LANE_W-1:0] rdata
);
    localparam int WORDS = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [WORDS];

        // Commit this lane when the write is enabled for it.
        always_ff @(posedge clk) begin
            if (we && !wlane_n[g]) mem[waddr] <= wdata[g*LANE_W +: LANE_W];
        end

        assign rdata[g*LANE_W +: LANE_W] = mem[raddr];
    end
endmodule

// File: rtl/zt_sram.sv
`timescale 1ns/100ps
// Zero-turnaround pipelined synchronous SRAM model (top).
// Commands are registered at a rising edge. Reads drive the bus in the cycle
// after the next edge. Writes take wdata at the second edge after their
// command. A same-word read that follows a write directly is forwarded from
// wdata per lane. Assumes linear_order is static for the length of a burst.
module zt_sram
    import zt_sram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cke_n,
    input  logic                    sel_a_n,
    input  logic                    sel_b,
    input  logic                    sel_c_n,
    input  logic                    advance,
    input  logic                    rd_nwr,
    input  logic [LANES-1:0]        lane_wr_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    linear_order,
    input  logic                    out_en_n,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES*LANE_W-1:0] rdata,
    output logic                    rdata_oe,
    inout  wire  [LANES*LANE_W-1:0] dq
);
    localparam int DATA_W  = LANES * LANE_W;
    localparam int BURST_W = 2;
    localparam int LATENCY = 2;

    logic              run;
    logic              chip_on;
    logic              burst_q;
    logic              burst_wr_q;
    logic              cmd_valid;
    logic              cmd_wr;
    logic [ADDR_W-1:0] cmd_addr;
    logic [ADDR_W-1:0] step_addr;
    logic              s1_valid;
    logic              s1_wr;
    logic [ADDR_W-1:0] s1_addr;
    logic              s2_valid;
    logic              s2_wr;
    logic [ADDR_W-1:0] s2_addr;
    logic [LANES-1:0]  s2_lane_n;
    logic [DATA_W-1:0] arr_rdata;
    logic [DATA_W-1:0] rd_word;
    logic              fwd_hit;
    logic [DATA_W-1:0] rdata_q;

    assign run     = !cke_n;
    assign chip_on = !sel_a_n && sel_b && !sel_c_n;

    // Burst state: a load records whether an access started and its direction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            burst_q    <= 1'b0;
            burst_wr_q <= 1'b0;
        end else if (run && !advance) begin
            burst_q    <= chip_on;
            burst_wr_q <= !rd_nwr;
        end
    end

    // Command issued this cycle: a fresh load or the continuation of the burst.
    always_comb begin
        if (advance) begin
            cmd_valid = burst_q;
            cmd_wr    = burst_wr_q;
            cmd_addr  = step_addr;
        end else begin
            cmd_valid = chip_on;
            cmd_wr    = !rd_nwr;
            cmd_addr  = addr;
        end
    end

    zt_burst_seq #(
        .ADDR_W (ADDR_W),
        .CW     (BURST_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (run && !advance && chip_on),
        .step      (run && advance && burst_q),
        .addr_in   (addr),
        .order     (linear_order),
        .step_addr (step_addr)
    );

    zt_cmd_pipe #(
        .ADDR_W (ADDR_W),
        .LANES  (LANES),
        .DEPTH  (LATENCY)
    ) u_pipe (
        .clk        (clk),
        .rst_n      (rst_n),
        .hold       (cke_n),
        .in_valid   (cmd_valid),
        .in_wr      (cmd_wr),
        .in_addr    (cmd_addr),
        .in_lane_n  (lane_wr_n),
        .mid_valid  (s1_valid),
        .mid_wr     (s1_wr),
        .mid_addr   (s1_addr),
        .out_valid  (s2_valid),
        .out_wr     (s2_wr),
        .out_addr   (s2_addr),
        .out_lane_n (s2_lane_n)
    );

    zt_byte_array #(
        .ADDR_W (ADDR_W),
        .LANES  (LANES)
    ) u_array (
        .clk     (clk),
        .we      (run && s2_valid && s2_wr),
        .waddr   (s2_addr),
        .wlane_n (s2_lane_n),
        .wdata   (wdata),
        .raddr   (s1_addr),
        .rdata   (arr_rdata)
    );

    // Forward lanes of the write committing at this edge into a same-word read.
    always_comb begin
        fwd_hit = s2_valid && s2_wr && (s2_addr == s1_addr);
        for (int i = 0; i < LANES; i++) begin
            rd_word[i*LANE_W +: LANE_W] = (fwd_hit && !s2_lane_n[i])
                ? wdata[i*LANE_W +: LANE_W]
                : arr_rdata[i*LANE_W +: LANE_W];
        end
    end

    // Output register: load the word of a read as it enters its data slot.
    always_ff @(posedge clk) begin
        if (!rst_n)                            rdata_q <= '0;
        else if (run && s1_valid && !s1_wr)    rdata_q <= rd_word;
    end

    assign rdata    = rdata_q;
    assign rdata_oe = s2_valid && !s2_wr && !out_en_n;
    assign dq       = rdata_oe ? rdata_q : {DATA_W{1'bz}};
endmodule

// File: rtl/zt_sram_chk.sv
`timescale 1ns/100ps
// Assertion checker for zt_sram, attached with bind. Observes the ports and
// the pipeline stage flags that the top module passes between its sub-blocks.
module zt_sram_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cke_n,
    input logic              advance,
    input logic              sel_a_n,
    input logic              sel_b,
    input logic              sel_c_n,
    input logic              out_en_n,
    input logic              rdata_oe,
    input logic [DATA_W-1:0] rdata,
    input logic              s1_valid,
    input logic              s1_wr,
    input logic              s2_valid,
    input logic              s2_wr
);
    // R3: a load with all enables active enters the pipeline
    a_r3_start_fills: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && !advance && !sel_a_n && sel_b && !sel_c_n) |=> s1_valid);

    // R3: a load with any enable inactive issues nothing
    a_r3_deselect_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && !advance && !(!sel_a_n && sel_b && !sel_c_n)) |=> !s1_valid);

    // R4: a continuation after an access keeps its direction
    a_r4_burst_type: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && advance && s1_valid) |=> (s1_valid && (s1_wr == $past(s1_wr))));

    // R9: a continuation after a deselect stays deselected
    a_r9_cont_deselect: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && advance && !s1_valid) |=> !s1_valid);

    // R2: a write moves into its data slot on the next enabled edge
    a_r2_write_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && s1_valid && s1_wr) |=> (s2_valid && s2_wr));

    // R7: a stalled edge changes neither the pipeline nor the read data
    a_r7_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
        cke_n |=> ($stable(rdata) && $stable(s1_valid) && $stable(s2_valid)));

    // R8: no drive in a write data slot
    a_r8_write_undriven: assert property (@(posedge clk) disable iff (!rst_n)
        (s2_valid && s2_wr) |-> !rdata_oe);

    // R8: inactive output enable keeps the bus off
    a_r8_oe_off: assert property (@(posedge clk) disable iff (!rst_n)
        out_en_n |-> !rdata_oe);
endmodule

bind zt_sram zt_sram_chk #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cke_n    (cke_n),
    .advance  (advance),
    .sel_a_n  (sel_a_n),
    .sel_b    (sel_b),
    .sel_c_n  (sel_c_n),
    .out_en_n (out_en_n),
    .rdata_oe (rdata_oe),
    .rdata    (rdata),
    .s1_valid (s1_valid),
    .s1_wr    (s1_wr),
    .s2_valid (s2_valid),
    .s2_wr    (s2_wr)
);

// File: tb/zt_sram_test.sv
`timescale 1ns/100ps
// Bench for zt_sram: a stimulus table walked by one loop against a golden
// array and a two-slot expectation model, then directed reset and
// output-enable cases.
module zt_sram_test;
    localparam int AW = 6;
    localparam int LN = 4;
    localparam int DW = LN * 8;
    localparam logic [2:0] ON = 3'b010;   // {sel_a_n, sel_b, sel_c_n} all active

    typedef struct packed {
        logic          cke_n;
        logic          adv;
        logic [2:0]    sel;
        logic          rd;
        logic [LN-1:0] be_n;
        logic [AW-1:0] addr;
        logic          lin;
        logic [3:0]    req;
    } vec_t;

    typedef struct packed {
        logic          valid;
        logic          wr;
        logic [AW-1:0] addr;
        logic [LN-1:0] be_n;
    } op_t;

    function automatic vec_t mk(logic c, logic a, logic [2:0] s, logic r,
                                logic [LN-1:0] b, logic [AW-1:0] ad, logic l,
                                logic [3:0] q);
        mk = '{cke_n: c, adv: a, sel: s, rd: r, be_n: b, addr: ad, lin: l, req: q};
    endfunction

    localparam int NV = 32;
    localparam vec_t VEC [NV] = '{
        mk(0,0,ON,    0,4'h0,6'h04,0,2),  // R2 write 04
        mk(0,0,ON,    0,4'h0,6'h05,0,2),  // R2 write 05
        mk(0,0,ON,    1,4'hF,6'h04,0,1),  // R1 read 04 right after writes
        mk(0,0,ON,    0,4'hA,6'h05,0,6),  // R6 write lanes 0 and 2 of 05
        mk(0,0,ON,    1,4'hF,6'h05,0,2),  // R2 same-word read, forwarded
        mk(0,0,ON,    0,4'h0,6'h08,0,5),  // R5 write burst from 08, XOR order
        mk(0,1,3'b101,1,4'h0,6'h3F,0,4),  // R4 continue, other fields ignored
        mk(1,1,ON,    1,4'h0,6'h00,0,7),  // R7 stall inside write burst
        mk(0,1,ON,    1,4'h0,6'h00,0,4),  // R4 continue write
        mk(0,1,ON,    1,4'h0,6'h00,0,4),  // R4 continue write
        mk(0,1,ON,    1,4'h0,6'h00,0,5),  // R5 wraps back to 08
        mk(0,0,ON,    1,4'hF,6'h0A,0,5),  // R5 read burst from 0A, XOR order
        mk(0,1,ON,    0,4'h0,6'h33,0,4),  // R4 continue read, rd_nwr ignored
        mk(1,0,ON,    0,4'h0,6'h00,0,7),  // R7 stall during read slot
        mk(0,1,ON,    0,4'h0,6'h00,0,5),  // R5 continue read
        mk(0,1,ON,    0,4'h0,6'h00,0,5),  // R5 continue read
        mk(0,0,3'b110,1,4'hF,6'h00,0,3),  // R3 deselect via sel_a_n
        mk(0,1,ON,    0,4'h0,6'h04,0,9),  // R9 continued deselect, no write
        mk(0,0,ON,    0,4'hF,6'h04,0,6),  // R6 write abort on 04
        mk(0,0,ON,    1,4'hF,6'h04,0,6),  // R6 read back 04 unchanged
        mk(0,0,ON,    0,4'h0,6'h1D,1,5),  // R5 write burst from 1D, add order
        mk(0,1,ON,    0,4'h0,6'h00,1,5),
        mk(0,1,ON,    0,4'h0,6'h00,1,5),
        mk(0,1,ON,    0,4'h0,6'h00,1,5),
        mk(0,0,ON,    1,4'hF,6'h1E,1,5),  // R5 read burst from 1E, add order
        mk(0,1,ON,    1,4'h0,6'h00,1,5),
        mk(0,1,ON,    1,4'h0,6'h00,1,5),
        mk(0,1,ON,    1,4'h0,6'h00,1,5),
        mk(0,0,3'b000,1,4'hF,6'h00,0,3),  // R3 deselect via sel_b
        mk(0,0,3'b011,0,4'h0,6'h08,0,3),  // R3 write with sel_c_n high ignored
        mk(0,0,ON,    1,4'hF,6'h08,0,5),  // R5 read 08 after wrap rewrite
        mk(0,0,3'b110,1,4'hF,6'h00,0,3)   // R3 deselect
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cke_n = 1'b0;
    logic          sel_a_n = 1'b1;
    logic          sel_b = 1'b0;
    logic          sel_c_n = 1'b1;
    logic          advance = 1'b0;
    logic          rd_nwr = 1'b1;
    logic [LN-1:0] lane_wr_n = '1;
    logic [AW-1:0] addr = '0;
    logic          linear_order = 1'b0;
    logic          out_en_n = 1'b0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          rdata_oe;
    wire  [DW-1:0] dq;

    zt_sram #(.ADDR_W(AW), .LANES(LN)) uut (
        .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .sel_a_n(sel_a_n),
        .sel_b(sel_b), .sel_c_n(sel_c_n), .advance(advance), .rd_nwr(rd_nwr),
        .lane_wr_n(lane_wr_n), .addr(addr), .linear_order(linear_order),
        .out_en_n(out_en_n), .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe),
        .dq(dq)
    );

    always #2 clk = ~clk;   // 250 MHz

    int tests = 0;
    int fails = 0;
    int stepn = 0;
    bit done  = 1'b0;

    // Golden model state
    logic [DW-1:0] gold [1 << AW];
    op_t           m1 = '0;
    op_t           m2 = '0;
    logic [DW-1:0] exp_q = '0;
    logic          b_act = 1'b0;
    logic          b_wr = 1'b0;
    logic [AW-1:0] b_base = '0;
    logic [1:0]    b_cnt = '0;

    task automatic check(input bit ok, input string req, input logic [DW-1:0] act,
                         input logic [DW-1:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s step %0d: actual %h expected %h", req, stepn, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] burst_addr(logic [AW-1:0] base, logic [1:0] cnt,
                                                 logic lin);
        logic [1:0] lo;
        lo = lin ? (base[1:0] + cnt) : (base[1:0] ^ cnt);
        return {base[AW-1:2], lo};
    endfunction

    // One cycle: drive at a falling edge, update the model after the rising
    // edge, check the data slot at the next falling edge.
    task automatic apply(input vec_t v);
        op_t nop;
        cke_n        = v.cke_n;
        advance      = v.adv;
        {sel_a_n, sel_b, sel_c_n} = v.sel;
        rd_nwr       = v.rd;
        lane_wr_n    = v.be_n;
        addr         = v.addr;
        linear_order = v.lin;
        if (m2.valid && m2.wr)
            wdata = {8'(stepn * 7 + 1), 8'(stepn + 64), 8'(stepn ^ 165), 8'(stepn * 3 + 2)};
        else
            wdata = 32'hDEAD_BEEF;
        @(posedge clk);
        #1;
        if (!v.cke_n) begin
            if (m2.valid && m2.wr)
                for (int i = 0; i < LN; i++)
                    if (!m2.be_n[i]) gold[m2.addr][i*8 +: 8] = wdata[i*8 +: 8];
            nop = '0;
            if (!v.adv) begin
                if (v.sel == ON) begin
                    nop = '{valid: 1'b1, wr: !v.rd, addr: v.addr, be_n: v.be_n};
                    b_act = 1'b1; b_wr = !v.rd; b_base = v.addr; b_cnt = 2'd0;
                end else begin
                    b_act = 1'b0;
                end
            end else if (b_act) begin
                b_cnt = b_cnt + 2'd1;
                nop = '{valid: 1'b1, wr: b_wr, addr: burst_addr(b_base, b_cnt, v.lin),
                        be_n: v.be_n};
            end
            m2 = m1;
            m1 = nop;
            if (m2.valid && !m2.wr) exp_q = gold[m2.addr];
        end
        @(negedge clk);
        begin
            bit exp_drive;
            exp_drive = m2.valid && !m2.wr && !out_en_n;
            check(rdata_oe == exp_drive, $sformatf("R%0d drive", v.req),
                  DW'(rdata_oe), DW'(exp_drive));
            if (exp_drive) begin
                check(rdata == exp_q, $sformatf("R%0d data", v.req), rdata, exp_q);
                check(dq == exp_q, $sformatf("R%0d bus", v.req), dq, exp_q);
            end
        end
        stepn++;
    endtask

    localparam vec_t DSEL = mk(0,0,3'b110,1,4'hF,6'h00,0,3);

    initial begin
        for (int i = 0; i < (1 << AW); i++) gold[i] = '0;
        repeat (3) @(negedge clk);
        check(rdata_oe == 1'b0, "R10 reset bus off", DW'(rdata_oe), '0);
        rst_n = 1'b1;

        for (int k = 0; k < NV; k++) apply(VEC[k]);
        apply(DSEL);
        apply(DSEL);

        // R8: output enable toggled inside a live read slot
        apply(mk(0,0,ON,1,4'hF,6'h05,0,1));
        apply(DSEL);
        out_en_n = 1'b1;
        #0.4;
        check(rdata_oe == 1'b0, "R8 oe off", DW'(rdata_oe), '0);
        out_en_n = 1'b0;
        #0.4;
        check(rdata_oe == 1'b1, "R8 oe on", DW'(rdata_oe), 1);
        check(rdata == gold[5], "R8 data after oe", rdata, gold[5]);
        apply(DSEL);

        // R10: reset in the middle of a read burst
        apply(mk(0,0,ON,1,4'hF,6'h04,0,10));
        apply(mk(0,1,ON,1,4'h0,6'h00,0,10));
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        m1 = '0; m2 = '0; b_act = 1'b0; b_cnt = '0;
        @(negedge clk);
        rst_n = 1'b1;
        check(rdata_oe == 1'b0, "R10 bus off after reset", DW'(rdata_oe), '0);
        apply(mk(0,1,ON,1,4'h0,6'h00,0,10));   // R10 acts as continued deselect
        apply(mk(0,1,ON,1,4'h0,6'h00,0,10));
        apply(mk(0,1,ON,1,4'h0,6'h00,0,10));

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule